// File: doc/BRIEF.md
# Two-Phase Randomized Mesh Route Computation

This block computes routes for one router in a 2D mesh. Each packet takes a detour through a randomly chosen intermediate node, which spreads traffic evenly over the mesh. The route is not minimal. When a packet is injected, the injection side draws an intermediate coordinate and hands back a phase bit. The network interface stores both in the packet header. At every hop, the hop side reads the current coordinate, the header's destination, the intermediate node and the phase bit. It returns one output port and the updated phase bit.

Both legs of the route use X-then-Y dimension order. The first leg runs from the source to the intermediate node, and the second leg runs from there to the destination. A load-gate mode skips the detour unless a high-load hint is asserted. A quadrant mode keeps the intermediate node in the same X half and Y half of the mesh as the destination. Random candidates come from a free-running 16-bit LFSR. A candidate that falls outside the allowed range is refused, and a fresh one is offered on the next cycle.

Top module: `rand_route`

## Requirements
- R1: The hop port is chosen against a target by correcting X before Y. The port is EAST when the current x is below the target x and WEST when it is above. Once x matches, the port is NORTH when the current y is below the target y and SOUTH when it is above. The port codes are LOCAL=0, EAST=1, WEST=2, NORTH=3, SOUTH=4.
- R2: The effective phase is the header phase OR'd with (current node equals intermediate node). While the effective phase is 0 the target is the intermediate node; while it is 1 the target is the destination. `hop_phase_o` returns the effective phase, so a phase of 1 is never cleared.
- R3: LOCAL is returned only when the effective phase is 1 and the current node equals the destination. In phase 0, reaching the destination without having visited the intermediate node is not an ejection.
- R4: The LFSR resets to 16'hACE1. It shifts left every cycle, whether or not an injection is requested, and the feedback bit state[15]^state[13]^state[12]^state[10] enters bit 0. The raw X draw is state[XW-1:0] and the raw Y draw is the next YW bits, where XW and YW are the clog2 widths of the mesh dimensions.
- R5: A raw draw that is outside its allowed range on either axis drives `inj_ready_o` low for that cycle. Without quadrant mode the allowed range is below the mesh dimension. With quadrant mode it is below the size of the destination's half.
- R6: An accepted random intermediate node is returned on `inj_mid_*_o`. `inj_phase_o` is 1 if that node equals the source or the destination, and 0 otherwise.
- R7: When load gating is on and the high-load hint is low, injection is direct. `inj_ready_o` follows `inj_valid_i`, the intermediate output equals the destination, and `inj_phase_o` is 1, whatever the LFSR holds.
- R8: In quadrant mode, each axis of the intermediate node is the base of the destination's half plus the raw draw. The base is 0 for the lower half and dim/2 for the upper half, so the node lies in the same X half and Y half as the destination.
- R9: `inj_ready_o` is low whenever `inj_valid_i` is low, including during reset.
- R10: The hop outputs are combinational and respond to their inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_gate_i | input | 1 | Take the detour only under high load |
| cfg_quad_i | input | 1 | Keep the intermediate node in the destination's quadrant |
| load_hi_i | input | 1 | High-load hint |
| inj_valid_i | input | 1 | Injection request |
| inj_src_x_i | input | XW | Source x |
| inj_src_y_i | input | YW | Source y |
| inj_dst_x_i | input | XW | Destination x |
| inj_dst_y_i | input | YW | Destination y |
| inj_ready_o | output | 1 | Header fields valid this cycle |
| inj_mid_x_o | output | XW | Intermediate x for the header |
| inj_mid_y_o | output | YW | Intermediate y for the header |
| inj_phase_o | output | 1 | Initial phase bit for the header |
| hop_cur_x_i | input | XW | This router's x |
| hop_cur_y_i | input | YW | This router's y |
| hop_dst_x_i | input | XW | Header destination x |
| hop_dst_y_i | input | YW | Header destination y |
| hop_mid_x_i | input | XW | Header intermediate x |
| hop_mid_y_i | input | YW | Header intermediate y |
| hop_phase_i | input | 1 | Header phase bit |
| hop_port_o | output | 3 | Selected output port |
| hop_phase_o | output | 1 | Updated phase bit |

## Verification
The bench checks that a packet standing on its destination in phase 0 is sent on toward the intermediate node and not ejected; a design that ejects it there skips the detour. It places the intermediate node on the current node so the phase flips in the same cycle, and it feeds phase 1 away from the intermediate node to catch a design that forgets the phase and drives packets back toward the detour. At injection it tracks the LFSR sequence from the stated seed. It checks that quadrant draws beyond the destination half's size are refused and that accepted nodes are offset into the correct half, which catches a design that wraps the draw or uses the source's quadrant. It also checks that a node equal to the source or destination starts in phase 1 and that a gated, low-load injection goes straight to the destination.

// File: rtl/rand_route_pkg.sv
package rand_route_pkg;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  localparam int unsigned RND_W = 16;
  localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;
endpackage

// File: rtl/rr_lfsr.sv
module rr_lfsr
  import rand_route_pkg::*;
#(
  parameter logic [RND_W-1:0] SEED = RND_SEED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [RND_W-1:0] state_o
);
  logic [RND_W-1:0] q;
  logic             fb;

  // x^16 + x^14 + x^13 + x^11 + 1
  assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= {q[RND_W-2:0], fb};
  end

  assign state_o = q;

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0); // R4
endmodule

// File: rtl/rr_axis_pick.sv
module rr_axis_pick #(
  parameter int unsigned DIM = 4,
  parameter int unsigned W   = 2
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] dst_i,
  input  logic         quad_i,
  output logic [W-1:0] sel_o,
  output logic         ok_o
);
  localparam int unsigned LO_N = DIM / 2;
  localparam int unsigned HI_N = DIM - LO_N;
  localparam logic [W:0] LO_L  = LO_N[W:0];
  localparam logic [W:0] HI_L  = HI_N[W:0];
  localparam logic [W:0] DIM_L = DIM[W:0];

  logic       dst_hi;
  logic [W:0] lim;
  logic [W-1:0] base;

  assign dst_hi = {1'b0, dst_i} >= LO_L;

  always_comb begin
    if (quad_i) begin
      lim  = dst_hi ? HI_L : LO_L;
      base = dst_hi ? LO_L[W-1:0] : '0;
    end else begin
      lim  = DIM_L;
      base = '0;
    end
  end

  // rejection sampling: out-of-range draws are refused, not folded
  assign ok_o  = {1'b0, raw_i} < lim;
  assign sel_o = base + raw_i;
endmodule

// File: rtl/rr_xy.sv
module rr_xy
  import rand_route_pkg::*;
#(
  parameter int unsigned XW = 2,
  parameter int unsigned YW = 2
) (
  input  logic [XW-1:0] cur_x_i,
  input  logic [YW-1:0] cur_y_i,
  input  logic [XW-1:0] tgt_x_i,
  input  logic [YW-1:0] tgt_y_i,
  output port_e         port_o
);
  always_comb begin
    if (cur_x_i < tgt_x_i)      port_o = PORT_EAST;
    else if (cur_x_i > tgt_x_i) port_o = PORT_WEST;
    else if (cur_y_i < tgt_y_i) port_o = PORT_NORTH;
    else if (cur_y_i > tgt_y_i) port_o = PORT_SOUTH;
    else                        port_o = PORT_LOCAL;
  end
endmodule

// File: rtl/rand_route.sv
module rand_route
  import rand_route_pkg::*;
#(
  parameter int unsigned MESH_X = 4,
  parameter int unsigned MESH_Y = 4,
  localparam int unsigned XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int unsigned YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_load_gate_i,
  input  logic          cfg_quad_i,
  input  logic          load_hi_i,
  input  logic          inj_valid_i,
  input  logic [XW-1:0] inj_src_x_i,
  input  logic [YW-1:0] inj_src_y_i,
  input  logic [XW-1:0] inj_dst_x_i,
  input  logic [YW-1:0] inj_dst_y_i,
  output logic          inj_ready_o,
  output logic [XW-1:0] inj_mid_x_o,
  output logic [YW-1:0] inj_mid_y_o,
  output logic          inj_phase_o,
  input  logic [XW-1:0] hop_cur_x_i,
  input  logic [YW-1:0] hop_cur_y_i,
  input  logic [XW-1:0] hop_dst_x_i,
  input  logic [YW-1:0] hop_dst_y_i,
  input  logic [XW-1:0] hop_mid_x_i,
  input  logic [YW-1:0] hop_mid_y_i,
  input  logic          hop_phase_i,
  output logic [2:0]    hop_port_o,
  output logic          hop_phase_o
);
  // ---------------- injection side ----------------
  logic [RND_W-1:0] rnd;
  logic [XW-1:0]    cand_x;
  logic [YW-1:0]    cand_y;
  logic             ok_x, ok_y, direct, hit_end;

  rr_lfsr #(.SEED(RND_SEED)) i_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_o(rnd)
  );

  rr_axis_pick #(.DIM(MESH_X), .W(XW)) i_pick_x (
    .raw_i (rnd[XW-1:0]),
    .dst_i (inj_dst_x_i),
    .quad_i(cfg_quad_i),
    .sel_o (cand_x),
    .ok_o  (ok_x)
  );

  rr_axis_pick #(.DIM(MESH_Y), .W(YW)) i_pick_y (
    .raw_i (rnd[XW+YW-1:XW]),
    .dst_i (inj_dst_y_i),
    .quad_i(cfg_quad_i),
    .sel_o (cand_y),
    .ok_o  (ok_y)
  );

  assign direct  = cfg_load_gate_i & ~load_hi_i;
  assign hit_end = ((cand_x == inj_src_x_i) && (cand_y == inj_src_y_i)) ||
                   ((cand_x == inj_dst_x_i) && (cand_y == inj_dst_y_i));

  assign inj_ready_o = inj_valid_i & (direct | (ok_x & ok_y));
  assign inj_mid_x_o = direct ? inj_dst_x_i : cand_x;
  assign inj_mid_y_o = direct ? inj_dst_y_i : cand_y;
  assign inj_phase_o = direct | hit_end;

  // ---------------- hop side ----------------
  logic          at_mid, phase_eff;
  logic [XW-1:0] tgt_x;
  logic [YW-1:0] tgt_y;
  port_e         port;

  assign at_mid    = (hop_cur_x_i == hop_mid_x_i) && (hop_cur_y_i == hop_mid_y_i);
  assign phase_eff = hop_phase_i | at_mid;
  assign tgt_x     = phase_eff ? hop_dst_x_i : hop_mid_x_i;
  assign tgt_y     = phase_eff ? hop_dst_y_i : hop_mid_y_i;

  rr_xy #(.XW(XW), .YW(YW)) i_xy (
    .cur_x_i(hop_cur_x_i),
    .cur_y_i(hop_cur_y_i),
    .tgt_x_i(tgt_x),
    .tgt_y_i(tgt_y),
    .port_o (port)
  );

  assign hop_port_o  = port;
  assign hop_phase_o = phase_eff;

  // ---------------- assertions ----------------
  AST_LOCAL_AT_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hop_port_o == 3'd0) |-> (hop_phase_o && hop_cur_x_i == hop_dst_x_i
                              && hop_cur_y_i == hop_dst_y_i)); // R3

  AST_PHASE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_phase_i |-> hop_phase_o); // R2

  AST_Y_AFTER_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hop_phase_o && (hop_port_o == 3'd3 || hop_port_o == 3'd4))
      |-> (hop_cur_x_i == hop_dst_x_i)); // R1

  AST_PORT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_port_o <= 3'd4); // R1

  AST_READY_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_ready_o |-> inj_valid_i); // R9

  AST_MID_IN_MESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_ready_o |-> (int'(inj_mid_x_o) < int'(MESH_X)
                     && int'(inj_mid_y_o) < int'(MESH_Y))); // R5

  AST_QUAD_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_ready_o && cfg_quad_i)
      |-> (((int'(inj_mid_x_o) >= int'(MESH_X / 2)) == (int'(inj_dst_x_i) >= int'(MESH_X / 2)))
        && ((int'(inj_mid_y_o) >= int'(MESH_Y / 2)) == (int'(inj_dst_y_i) >= int'(MESH_Y / 2))))); // R8

  AST_DIRECT_INJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_valid_i && cfg_load_gate_i && !load_hi_i)
      |-> (inj_ready_o && inj_phase_o && inj_mid_x_o == inj_dst_x_i
           && inj_mid_y_o == inj_dst_y_i)); // R7
endmodule

// File: tb/test_rand_route.sv
`timescale 1ns/1ps
module test_rand_route;
  localparam int MX = 4;
  localparam int MY = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate, quad, load_hi, inj_valid;
  logic [1:0] src_x, src_y, dst_x, dst_y;
  logic       inj_ready, inj_phase;
  logic [1:0] mid_x, mid_y;
  logic [1:0] cur_x, cur_y, hdst_x, hdst_y, hmid_x, hmid_y;
  logic       hph;
  logic [2:0] port;
  logic       ph_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rand_route #(.MESH_X(MX), .MESH_Y(MY)) i_rand_route (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_load_gate_i(gate), .cfg_quad_i(quad), .load_hi_i(load_hi),
    .inj_valid_i(inj_valid),
    .inj_src_x_i(src_x), .inj_src_y_i(src_y),
    .inj_dst_x_i(dst_x), .inj_dst_y_i(dst_y),
    .inj_ready_o(inj_ready), .inj_mid_x_o(mid_x), .inj_mid_y_o(mid_y),
    .inj_phase_o(inj_phase),
    .hop_cur_x_i(cur_x), .hop_cur_y_i(cur_y),
    .hop_dst_x_i(hdst_x), .hop_dst_y_i(hdst_y),
    .hop_mid_x_i(hmid_x), .hop_mid_y_i(hmid_y),
    .hop_phase_i(hph), .hop_port_o(port), .hop_phase_o(ph_o)
  );

  // reference sequence from the stated seed and taps
  logic [15:0] m_lfsr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_lfsr <= 16'hACE1;
    else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // {cx,cy,dx,dy,mx,my,ph,port,phase_o}
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    {2'd0,2'd0, 2'd3,2'd3, 2'd2,2'd1, 1'b0, 3'd1, 1'b0},
    {2'd2,2'd0, 2'd3,2'd3, 2'd2,2'd1, 1'b0, 3'd3, 1'b0},
    {2'd2,2'd1, 2'd3,2'd3, 2'd2,2'd1, 1'b0, 3'd1, 1'b1},
    {2'd3,2'd1, 2'd3,2'd3, 2'd2,2'd1, 1'b1, 3'd3, 1'b1},
    {2'd3,2'd3, 2'd3,2'd3, 2'd2,2'd1, 1'b1, 3'd0, 1'b1},
    {2'd3,2'd3, 2'd3,2'd3, 2'd0,2'd0, 1'b0, 3'd2, 1'b0},
    {2'd1,2'd2, 2'd1,2'd2, 2'd1,2'd2, 1'b0, 3'd0, 1'b1},
    {2'd3,2'd2, 2'd0,2'd0, 2'd1,2'd3, 1'b0, 3'd2, 1'b0},
    {2'd1,2'd2, 2'd0,2'd0, 2'd1,2'd3, 1'b0, 3'd3, 1'b0},
    {2'd1,2'd3, 2'd0,2'd0, 2'd1,2'd3, 1'b0, 3'd2, 1'b1},
    {2'd0,2'd3, 2'd0,2'd0, 2'd1,2'd3, 1'b1, 3'd4, 1'b1},
    {2'd0,2'd1, 2'd0,2'd0, 2'd2,2'd2, 1'b1, 3'd4, 1'b1},
    {2'd2,2'd2, 2'd0,2'd2, 2'd2,2'd2, 1'b1, 3'd2, 1'b1},
    {2'd0,2'd2, 2'd2,2'd2, 2'd0,2'd2, 1'b1, 3'd1, 1'b1}
  };

  // expected per-axis pick for a 4-wide axis
  task automatic axis_exp(input logic [1:0] raw, input logic [1:0] d, input logic q,
                          output logic ok, output logic [1:0] sel);
    if (!q) begin
      ok = 1'b1; sel = raw;
    end else begin
      ok  = raw < 2'd2;
      sel = (d >= 2'd2) ? raw + 2'd2 : raw;
    end
  endtask

  initial begin
    gate = 0; quad = 0; load_hi = 0; inj_valid = 0;
    src_x = 0; src_y = 0; dst_x = 0; dst_y = 0;
    cur_x = 0; cur_y = 0; hdst_x = 0; hdst_y = 0; hmid_x = 0; hmid_y = 0; hph = 0;
    #5;
    chk("R9 ready in reset", int'(inj_ready), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 ready idle", int'(inj_ready), 0);
    inj_valid = 1'b1; src_x = 2'd3; src_y = 2'd3; dst_x = 2'd2; dst_y = 2'd2;
    #1;
    // seed 16'hACE1: x=1, y=0
    chk("R4 seed draw x", int'(mid_x), 1);
    chk("R4 seed draw y", int'(mid_y), 0);
    chk("R6 seed phase", int'(inj_phase), 0);

    // hop table (R10: checked in the same cycle as the drive)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {cur_x, cur_y, hdst_x, hdst_y, hmid_x, hmid_y, hph} = VEC[v][16:4];
      #1;
      chk($sformatf("R1 R2 R3 R10 vec%0d port", v), int'(port), int'(VEC[v][3:1]));
      chk($sformatf("R2 R3 vec%0d phase", v), int'(ph_o), int'(VEC[v][0]));
    end

    // injection sweep over modes, following the reference sequence
    for (int i = 0; i < 96; i++) begin
      logic okx, oky, exp_rdy, exp_ph;
      logic [1:0] ex, ey;
      @(negedge clk);
      quad = i[1]; gate = i[2]; load_hi = i[3];
      src_x = 2'((i * 5) % 4);     src_y = 2'((i * 3 + 1) % 4);
      dst_x = 2'((i * 7 + 3) % 4); dst_y = 2'((i / 4) % 4);
      inj_valid = (i % 11) != 5;
      #1;
      if (gate && !load_hi) begin
        chk("R7 direct ready", int'(inj_ready), int'(inj_valid));
        chk("R7 direct mid", int'({mid_x, mid_y}), int'({dst_x, dst_y}));
        chk("R7 direct phase", int'(inj_phase), 1);
      end else begin
        axis_exp(m_lfsr[1:0], dst_x, quad, okx, ex);
        axis_exp(m_lfsr[3:2], dst_y, quad, oky, ey);
        exp_rdy = inj_valid && okx && oky;
        chk(quad ? "R5 R9 quad ready" : "R5 R9 ready", int'(inj_ready), int'(exp_rdy));
        if (exp_rdy) begin
          exp_ph = ({ex, ey} == {src_x, src_y}) || ({ex, ey} == {dst_x, dst_y});
          chk(quad ? "R8 quad mid" : "R4 R6 mid", int'({mid_x, mid_y}), int'({ex, ey}));
          chk("R6 phase", int'(inj_phase), int'(exp_ph));
        end
      end
    end

    // endpoint hit: source chosen equal to the current draw
    @(negedge clk);
    gate = 0; quad = 0; inj_valid = 1;
    src_x = m_lfsr[1:0]; src_y = m_lfsr[3:2];
    dst_x = ~m_lfsr[1:0]; dst_y = m_lfsr[3:2];
    #1;
    chk("R6 mid equals source", int'(inj_phase), 1);
    @(negedge clk);
    dst_x = m_lfsr[1:0]; dst_y = m_lfsr[3:2];
    src_x = ~m_lfsr[1:0]; src_y = ~m_lfsr[3:2];
    #1;
    chk("R6 mid equals dest", int'(inj_phase), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule